// File: doc/BRIEF.md
# Video line symbol sequencer

The sequencer generates the 30-bit symbol stream for one scanline after another of a DVI/HDMI-style display link. Every symbol packs three 10-bit lane symbols: lane 0 in bits 9:0, lane 1 in bits 19:10 and lane 2 in bits 29:20. It walks a frame made of vertical front-porch, vertical-sync, vertical back-porch and active lines. Each line holds a horizontal front porch, the horizontal sync, the back porch and the active-pixel span. Outside the pixel and island windows the block emits control-period symbols: the sync levels, a video preamble and a leading guard band ahead of active pixels, and a data-island preamble on the first vertical-sync line.

Two window flags tell a downstream multiplexer where it can insert content. `active_win` marks pixel symbols, which this block leaves at zero. `island_win` marks the island slot, where the block passes the `island_data` word through. Pixel encoding and the island payload are produced elsewhere.

The output is a valid/ready stream. `sym_valid` rises one cycle after reset is released and then stays high. A symbol is consumed on a rising edge where `sym_valid` and `sym_ready` are both high. While `sym_ready` is low the sequencer keeps its position, and `sym_data` and both flags stay unchanged. In the island window `sym_data` follows `island_data`, so the island source must hold its word steady until that symbol is consumed.

Top module: `video_line_seq`

## Requirements
- R1: While `rst` is high, `sym_valid` is 0 and `frame_cnt` is 0. The first symbol offered after reset is symbol 0 of line 0.
- R2: A lane control symbol encodes its two control bits as 00 → 0x354, 01 → 0x0AB, 10 → 0x154 and 11 → 0x2AB. Lane 0 carries {vsync, hsync}, with vsync as the upper bit. In plain blanking, lanes 1 and 2 carry control 00.
- R3: Each line is H_FP front-porch symbols, then H_SYNC sync symbols, then H_BP back-porch symbols, then H_ACT active symbols. On lines that are not active lines, the back-porch symbol continues through the active span.
- R4: Hsync is active low. During the H_SYNC symbols, lane 0 has hsync = 0. Everywhere else it has hsync = 1.
- R5: Vsync is active low. On the V_SYNC lines that follow the V_FP front-porch lines, lane 0 has vsync = 0. On all other lines it has vsync = 1.
- R6: On active lines, the last PRE_W + GB_W back-porch symbols are replaced. First come PRE_W video-preamble symbols: lane 0 control 11, lane 1 control 01, lane 2 control 00. Then come GB_W guard symbols: 0x2CC, 0x133 and 0x2CC on lanes 0, 1 and 2.
- R7: Active lines are the last V_ACT lines of the frame. On these lines `active_win` is 1 exactly on the H_ACT active symbols, and `sym_data` is 0 there. Everywhere else `active_win` is 0.
- R8: On the first vsync line only, the last PRE_W + ISL_W symbols of the hsync period are replaced. First come PRE_W island-preamble symbols: lane 0 control 00, lanes 1 and 2 control 01. Then come ISL_W symbols where `island_win` = 1 and `sym_data` equals `island_data`. Everywhere else `island_win` is 0.
- R9: `frame_cnt` increments, modulo 2^FRAME_W, when the stream moves onto symbol 0 of the first vsync line.
- R10: While `sym_valid` is 1 and `sym_ready` is 0, the position does not advance, and `sym_data` and both flags hold. In the island window `sym_data` follows a held `island_data`.
- R11: Once `sym_valid` has risen after reset, it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_ready | input | 1 | Downstream accepts the current symbol |
| island_data | input | 30 | Island word passed through during the island window |
| sym_valid | output | 1 | A symbol is offered |
| sym_data | output | 30 | Three packed 10-bit lane symbols |
| active_win | output | 1 | Current symbol is an active-pixel slot |
| island_win | output | 1 | Current symbol is an island slot |
| frame_cnt | output | FRAME_W | Count of frames started |

## Verification
The assertions watch several rules on every cycle. They check that a stall freezes the horizontal position, the symbol and the flags, that `sym_valid` never drops after rising, and that the frame count changes only on the first vsync line. They also check that an island window always follows the island-preamble symbol and an active window always follows a guard symbol. The full symbol sequence cannot be proven cycle by cycle from inside the design. That includes the exact widths of every shortened porch and sync span, the control codes on each lane, and the frame count wrapping. The bench shows these by sweeping whole frames of a small timing with random back-pressure and comparing every symbol against a position model.

// File: rtl/vlss_pkg.sv
package vlss_pkg;

  localparam int LANE_W = 10;
  localparam int SYM_W  = 3 * LANE_W;

  typedef logic [LANE_W-1:0] lane_sym_t;
  typedef logic [SYM_W-1:0]  sym_word_t;

  localparam lane_sym_t GUARD_OUTER = 10'h2CC;
  localparam lane_sym_t GUARD_MID   = 10'h133;

  typedef enum logic [2:0] {
    SEG_PLAIN,
    SEG_VID_PRE,
    SEG_GUARD,
    SEG_ACTIVE,
    SEG_ISL_PRE,
    SEG_ISLAND
  } seg_e;

  // Control-period code for a pair of control bits {c1, c0}.
  function automatic lane_sym_t ctrl_code(input logic [1:0] pair);
    lane_sym_t code;
    case (pair)
      2'b00:   code = 10'h354;
      2'b01:   code = 10'h0AB;
      2'b10:   code = 10'h154;
      default: code = 10'h2AB;
    endcase
    return code;
  endfunction

  function automatic sym_word_t join_lanes(input lane_sym_t l0, input lane_sym_t l1,
                                           input lane_sym_t l2);
    return {l2, l1, l0};
  endfunction

endpackage

// File: rtl/vlss_hcount.sv
module vlss_hcount #(
  parameter int H_TOTAL = 2200,
  localparam int HW = $clog2(H_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [HW-1:0] h_pos,
  output logic          eol
);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);

  assign eol = (h_pos == H_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_pos <= '0;
    end else if (step) begin
      h_pos <= eol ? '0 : h_pos + 1'b1;
    end
  end

  // R10: no step, no movement
  p_hpos_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(h_pos));

  // R3: a step inside the line moves exactly one symbol on
  p_hpos_walk_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !eol) |=> (h_pos == $past(h_pos) + 1'b1));

endmodule

// File: rtl/vlss_vcount.sv
module vlss_vcount #(
  parameter int V_FP    = 4,
  parameter int V_TOTAL = 1125,
  parameter int FRAME_W = 16,
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  output logic [VW-1:0]      v_line,
  output logic [FRAME_W-1:0] frame_cnt
);

  localparam logic [VW-1:0] V_LAST   = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] VS_FIRST = VW'(V_FP);

  logic [VW-1:0] v_nxt;

  assign v_nxt = (v_line == V_LAST) ? '0 : v_line + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_line    <= '0;
      frame_cnt <= '0;
    end else if (step) begin
      v_line <= v_nxt;
      if (v_nxt == VS_FIRST) begin
        frame_cnt <= frame_cnt + 1'b1;
      end
    end
  end

  // R9: frame count only moves as the first vsync line is entered
  p_frame_on_vsync_r9: assert property (@(posedge clk) disable iff (rst)
    (frame_cnt != $past(frame_cnt)) |-> (v_line == VS_FIRST));

  // R5: line index never leaves the frame
  p_line_range_r5: assert property (@(posedge clk) disable iff (rst)
    v_line <= V_LAST);

endmodule

// File: rtl/vlss_compose.sv
module vlss_compose
  import vlss_pkg::*;
#(
  parameter int H_FP   = 88,
  parameter int H_SYNC = 44,
  parameter int H_BP   = 148,
  parameter int H_ACT  = 1920,
  parameter int V_FP   = 4,
  parameter int V_SYNC = 5,
  parameter int V_BP   = 36,
  parameter int V_ACT  = 1080,
  parameter int PRE_W  = 8,
  parameter int GB_W   = 2,
  parameter int ISL_W  = 32,
  localparam int H_TOTAL = H_FP + H_SYNC + H_BP + H_ACT,
  localparam int V_TOTAL = V_FP + V_SYNC + V_BP + V_ACT,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic [HW-1:0] h_pos,
  input  logic [VW-1:0] v_line,
  input  sym_word_t island_data,
  output sym_word_t sym,
  output logic      active_win,
  output logic      island_win
);

  localparam int BP_BEG_I  = H_FP + H_SYNC;
  localparam int ACT_BEG_I = BP_BEG_I + H_BP;

  localparam logic [HW-1:0] SYNC_BEG    = HW'(H_FP);
  localparam logic [HW-1:0] BP_BEG      = HW'(BP_BEG_I);
  localparam logic [HW-1:0] ACT_BEG     = HW'(ACT_BEG_I);
  localparam logic [HW-1:0] ISL_PRE_BEG = HW'(BP_BEG_I - PRE_W - ISL_W);
  localparam logic [HW-1:0] ISL_BEG     = HW'(BP_BEG_I - ISL_W);
  localparam logic [HW-1:0] VPRE_BEG    = HW'(ACT_BEG_I - PRE_W - GB_W);
  localparam logic [HW-1:0] GUARD_BEG   = HW'(ACT_BEG_I - GB_W);

  localparam logic [VW-1:0] VS_BEG   = VW'(V_FP);
  localparam logic [VW-1:0] VS_END   = VW'(V_FP + V_SYNC);
  localparam logic [VW-1:0] VACT_BEG = VW'(V_FP + V_SYNC + V_BP);

  localparam sym_word_t ISL_PRE_SYM = join_lanes(ctrl_code(2'b00), ctrl_code(2'b01),
                                                 ctrl_code(2'b01));
  localparam sym_word_t GUARD_SYM   = join_lanes(GUARD_OUTER, GUARD_MID, GUARD_OUTER);

  logic vs_n, hs_n, act_line, first_vs;
  seg_e seg;

  // Vertical classification of the current line.
  always_comb begin
    vs_n     = !((v_line >= VS_BEG) && (v_line < VS_END));
    act_line = !(v_line < VACT_BEG);
    first_vs = (v_line == VS_BEG);
  end

  // Horizontal segment of the current symbol.
  always_comb begin
    hs_n = 1'b1;
    seg  = SEG_PLAIN;
    if (h_pos < SYNC_BEG) begin
      seg = SEG_PLAIN;
    end else if (h_pos < BP_BEG) begin
      hs_n = 1'b0;
      if (first_vs && !(h_pos < ISL_PRE_BEG)) begin
        seg = (h_pos < ISL_BEG) ? SEG_ISL_PRE : SEG_ISLAND;
      end
    end else if (h_pos < ACT_BEG) begin
      if (act_line && !(h_pos < VPRE_BEG)) begin
        seg = (h_pos < GUARD_BEG) ? SEG_VID_PRE : SEG_GUARD;
      end
    end else if (act_line) begin
      seg = SEG_ACTIVE;
    end
  end

  // Symbol build from segment and sync levels.
  always_comb begin
    case (seg)
      SEG_VID_PRE: sym = join_lanes(ctrl_code({vs_n, hs_n}), ctrl_code(2'b01),
                                    ctrl_code(2'b00));
      SEG_GUARD:   sym = GUARD_SYM;
      SEG_ACTIVE:  sym = '0;
      SEG_ISL_PRE: sym = join_lanes(ctrl_code({vs_n, hs_n}), ctrl_code(2'b01),
                                    ctrl_code(2'b01));
      SEG_ISLAND:  sym = island_data;
      default:     sym = join_lanes(ctrl_code({vs_n, hs_n}), ctrl_code(2'b00),
                                    ctrl_code(2'b00));
    endcase
    active_win = (seg == SEG_ACTIVE);
    island_win = (seg == SEG_ISLAND);
  end

  // R8: an island window opens right after the island preamble
  p_island_after_pre_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(island_win) |-> ($past(sym) == ISL_PRE_SYM));

  // R6: active pixels open right after a guard symbol
  p_active_after_guard_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(active_win) |-> ($past(sym) == GUARD_SYM));

endmodule

// File: rtl/video_line_seq.sv
module video_line_seq
  import vlss_pkg::*;
#(
  parameter int H_FP    = 88,
  parameter int H_SYNC  = 44,
  parameter int H_BP    = 148,
  parameter int H_ACT   = 1920,
  parameter int V_FP    = 4,
  parameter int V_SYNC  = 5,
  parameter int V_BP    = 36,
  parameter int V_ACT   = 1080,
  parameter int PRE_W   = 8,
  parameter int GB_W    = 2,
  parameter int ISL_W   = 32,
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sym_ready,
  input  logic [29:0]        island_data,
  output logic               sym_valid,
  output logic [29:0]        sym_data,
  output logic               active_win,
  output logic               island_win,
  output logic [FRAME_W-1:0] frame_cnt
);

  localparam int H_TOTAL = H_FP + H_SYNC + H_BP + H_ACT;
  localparam int V_TOTAL = V_FP + V_SYNC + V_BP + V_ACT;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  logic          valid_q;
  logic          advance;
  logic          eol;
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_line;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= 1'b1;
  end

  assign sym_valid = valid_q;
  assign advance   = valid_q & sym_ready;

  vlss_hcount #(.H_TOTAL(H_TOTAL)) u_h (
    .clk   (clk),
    .rst   (rst),
    .step  (advance),
    .h_pos (h_pos),
    .eol   (eol)
  );

  vlss_vcount #(.V_FP(V_FP), .V_TOTAL(V_TOTAL), .FRAME_W(FRAME_W)) u_v (
    .clk       (clk),
    .rst       (rst),
    .step      (advance & eol),
    .v_line    (v_line),
    .frame_cnt (frame_cnt)
  );

  vlss_compose #(
    .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP), .H_ACT(H_ACT),
    .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP), .V_ACT(V_ACT),
    .PRE_W(PRE_W), .GB_W(GB_W), .ISL_W(ISL_W)
  ) u_c (
    .clk         (clk),
    .rst         (rst),
    .h_pos       (h_pos),
    .v_line      (v_line),
    .island_data (island_data),
    .sym         (sym_data),
    .active_win  (active_win),
    .island_win  (island_win)
  );

  // R11: valid never drops once raised
  p_valid_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> sym_valid);

  // R10: a stalled symbol and its flags hold (island words follow their source)
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && !sym_ready && !island_win) |=>
      ($stable(sym_data) && $stable(active_win) && $stable(island_win)));

  // R1: nothing offered during reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!sym_valid && frame_cnt == '0));

endmodule

// File: tb/sim_video_line_seq.sv
module sim_video_line_seq;

  localparam int H_FP = 2, H_SYNC = 7, H_BP = 6, H_ACT = 4;
  localparam int V_FP = 2, V_SYNC = 2, V_BP = 1, V_ACT = 3;
  localparam int PRE_W = 2, GB_W = 2, ISL_W = 3, FRAME_W = 3;
  localparam int H_TOTAL = H_FP + H_SYNC + H_BP + H_ACT;
  localparam int V_TOTAL = V_FP + V_SYNC + V_BP + V_ACT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_ready = 1'b0;
  logic [29:0] island_data = '0;
  logic sym_valid, active_win, island_win;
  logic [29:0] sym_data;
  logic [FRAME_W-1:0] frame_cnt;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  video_line_seq #(
    .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP), .H_ACT(H_ACT),
    .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP), .V_ACT(V_ACT),
    .PRE_W(PRE_W), .GB_W(GB_W), .ISL_W(ISL_W), .FRAME_W(FRAME_W)
  ) u0 (
    .clk(clk), .rst(rst), .sym_ready(sym_ready), .island_data(island_data),
    .sym_valid(sym_valid), .sym_data(sym_data), .active_win(active_win),
    .island_win(island_win), .frame_cnt(frame_cnt)
  );

  // R2 code table
  function automatic logic [9:0] cc(input int b1, input int b0);
    int k;
    k = b1 * 2 + b0;
    case (k)
      0: return 10'h354;
      1: return 10'h0AB;
      2: return 10'h154;
      default: return 10'h2AB;
    endcase
  endfunction

  function automatic void model(input int h, input int v, input logic [29:0] isl,
                                output logic [29:0] s, output logic a, output logic i,
                                output string tag);
    int vs;
    bit vsl, actl, first;
    vsl   = (v >= V_FP) && (v < V_FP + V_SYNC);
    vs    = vsl ? 0 : 1;
    actl  = (v >= V_TOTAL - V_ACT);
    first = (v == V_FP);
    a = 1'b0;
    i = 1'b0;
    s = {cc(0, 0), cc(0, 0), cc(vs, 1)};
    tag = vsl ? "R5" : "R3";
    if (h < H_FP) begin
      // front porch, plain symbol
    end else if (h < H_FP + H_SYNC) begin
      tag = "R4";
      s = {cc(0, 0), cc(0, 0), cc(vs, 0)};
      if (first && h >= H_FP + H_SYNC - PRE_W - ISL_W) begin
        tag = "R8";
        if (h < H_FP + H_SYNC - ISL_W) s = {cc(0, 1), cc(0, 1), cc(0, 0)};
        else begin s = isl; i = 1'b1; end
      end
    end else if (h < H_TOTAL - H_ACT) begin
      if (actl && h >= H_TOTAL - H_ACT - PRE_W - GB_W) begin
        tag = "R6";
        if (h < H_TOTAL - H_ACT - GB_W) s = {cc(0, 0), cc(0, 1), cc(1, 1)};
        else s = {10'h2CC, 10'h133, 10'h2CC};
      end
    end else if (actl) begin
      tag = "R7";
      a = 1'b1;
      s = '0;
    end
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stim
    int mh, mv, mframe, frames_done;
    bit moved, stalled, first_vec;
    logic [29:0] es;
    logic ea, ei;
    string tag;
    mh = 0; mv = 0; mframe = 0; frames_done = 0;
    moved = 0; stalled = 0; first_vec = 1;
    void'($urandom(7));
    // R1: reset state
    repeat (4) begin
      @(negedge clk);
      check("R1 valid in reset", 32'(sym_valid), 32'd0);
      check("R1 frame in reset", 32'(frame_cnt), 32'd0);
    end
    rst = 1'b0;
    @(negedge clk);
    while (frames_done < 10) begin
      if (moved) island_data = 30'($urandom);
      #1;
      model(mh, mv, island_data, es, ea, ei, tag);
      if (first_vec) tag = "R1";
      else if (stalled) tag = "R10";
      check({tag, " data"}, 32'(sym_data), 32'(es));
      check({tag, " flags"}, {30'd0, active_win, island_win}, {30'd0, ea, ei});
      check("R9 frame count", 32'(frame_cnt), 32'(mframe));
      check("R11 valid", 32'(sym_valid), 32'd1);
      first_vec = 0;
      if (frames_done < 1) sym_ready = 1'b1;
      else if (frames_done == 5) sym_ready = (($urandom % 8) == 0);
      else sym_ready = (($urandom % 3) != 0);
      moved = sym_ready && sym_valid;
      stalled = !moved;
      if (moved) begin
        mh++;
        if (mh == H_TOTAL) begin
          mh = 0;
          mv = (mv + 1) % V_TOTAL;
          if (mv == V_FP) begin
            mframe = (mframe + 1) % (1 << FRAME_W);
            frames_done++;
          end
        end
      end
      @(negedge clk);
    end
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule